// File: doc/BRIEF.md
# UART Boot Command Front-End

This block runs the opening handshake of a serial in-system-programming session. It sits between a byte-level UART (receiver and transmitter) and a set of mode handlers. After reset it listens at the default 9600 bps rate for the sync byte 5Ah and echoes it back. The next byte selects the line rate. The block checks that byte against the rates that are legal for the configured core clock and echoes it at the old rate. The new divisor is applied only once that echo has left the wire. The block then takes an operation command, echoes it and hands control to the matching mode handler through a start/done handshake.

Protocol faults (a bad rate byte, a bad command, a framing error or an overrun) are reported as the same error code sent three times in a row. The block then enters a silent lockout that only an asynchronous reset clears. The UART bit engine, the memories and the mode handlers are outside this block. Received bytes arrive as one-cycle valid pulses carrying two fault flags. Transmit bytes leave through a valid/ready port, and a one-cycle `tx_done` pulse from the UART marks the end of each stop bit.

Top module: `isp_boot_frontend`

## Requirements
- R1: After reset `tx_valid`, `mode_start` and `error_locked` are low, and `baud_div` equals round(clock/9600). The clock for setting `clk_sel`=s is 2 MHz·2^s, and round(f/b) is computed as (f + b/2)/b in integer division.
- R2: While waiting for sync, only a byte 5Ah received without a framing or overrun flag is echoed. Its echo (5Ah) raises `tx_valid` in the first cycle after the receive pulse. Any other byte, or 5Ah carrying a fault flag, gets no reply, and the block keeps waiting.
- R3: The rate byte codes are 04h=76800, 05h=62500, 07h=38400, 0Ah=31250, 18h=19200 and 28h=9600 bps. A code is legal when its rate does not exceed the top rate for the clock setting: 9600 at s=0, 31250 at s=1, 62500 at s=2 and 76800 at s=3. A legal code is echoed unchanged.
- R4: `baud_div` keeps its old value while the rate echo is being sent. It takes round(clock/new rate) in the cycle after the `tx_done` pulse that ends the echo.
- R5: A rate byte that is not a legal code is answered with 62h three times. The block then locks.
- R6: The commands 30h, 60h, 90h and C0h are echoed unchanged. `mode_start` then pulses for exactly one cycle, in the cycle after the echo's `tx_done`. During that pulse `mode_op` is 0, 1, 2 or 3 respectively.
- R7: Any other command byte is answered with 63h three times. The block then locks.
- R8: In the rate or command phase, a byte flagged with a framing error is answered with A1h three times, and a byte flagged with an overrun is answered with A3h three times. The framing flag wins when both are set. Either case ends in lockout.
- R9: In lockout `error_locked` is high. Received bytes get no reply and no mode starts, until reset.
- R10: When `mode_done` arrives for ops 0, 2 or 3, the next byte is treated as a command, not as sync. After op 1 (RAM load) the block stays passive: no reply to any byte and `error_locked` low.
- R11: Bytes received while an echo, an error report or a mode run is in progress are ignored. `tx_data` holds steady while `tx_valid` waits for `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Core clock setting (2 MHz·2^clk_sel), static while out of reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error flag for this byte |
| rx_overrun | input | 1 | Overrun flag for this byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_done | input | 1 | One-cycle pulse: the last accepted byte has been fully sent |
| baud_div | output | 16 | Clock cycles per bit for the UART |
| mode_start | output | 1 | One-cycle start of the selected mode handler |
| mode_op | output | 2 | Selected operation (0 flash write, 1 RAM load, 2 flash sum, 3 identification) |
| mode_done | input | 1 | Mode handler finished |
| error_locked | output | 1 | Lockout after a reported error |

## Verification
Every echo or error code appears on `tx_valid` in the first cycle after the receive pulse or after the previous `tx_done`. The bench drives inputs and samples outputs on the falling edge, so it checks the echo one falling edge after it releases `rx_valid`. Three results land in the cycle that follows a `tx_done` pulse: the new divisor, the `mode_start` pulse and `error_locked`. The bench samples them at the falling edge right after it drops `tx_done`, and it samples the old divisor just before raising that pulse. Quiet outcomes are checked by watching `tx_valid` and `mode_start` stay low over a fixed window of cycles. The bench sweeps every rate byte under every clock setting and every command byte.

// File: rtl/isp_boot_pkg.sv
package isp_boot_pkg;

  localparam int NUM_RATES = 6;
  localparam logic [7:0] SYNC_BYTE = 8'h5A;
  localparam logic [7:0] ERR_RATE  = 8'h62;
  localparam logic [7:0] ERR_CMD   = 8'h63;
  localparam logic [7:0] ERR_FRAME = 8'hA1;
  localparam logic [7:0] ERR_OVR   = 8'hA3;

  typedef enum logic [3:0] {
    ST_SYNC, ST_ECHO_SYNC, ST_RATE, ST_ECHO_RATE, ST_CMD,
    ST_ECHO_CMD, ST_RUN, ST_REPORT, ST_LOCK, ST_HANDOFF
  } fe_state_t;

  typedef enum logic [1:0] {
    OP_FLASH_WR = 2'd0, OP_RAM_LOAD = 2'd1, OP_FLASH_SUM = 2'd2, OP_IDENT = 2'd3
  } op_t;

  typedef struct packed {
    logic hit;
    op_t  op;
  } cmd_dec_t;

  // rate table slot -> code on the wire
  function automatic logic [7:0] rate_code(input int idx);
    case (idx)
      0: return 8'h04;
      1: return 8'h05;
      2: return 8'h07;
      3: return 8'h0A;
      4: return 8'h18;
      default: return 8'h28;
    endcase
  endfunction

  // rate table slot -> bits per second
  function automatic int unsigned rate_bps(input int idx);
    case (idx)
      0: return 76800;
      1: return 62500;
      2: return 38400;
      3: return 31250;
      4: return 19200;
      default: return 9600;
    endcase
  endfunction

  // rounded clock cycles per bit
  function automatic int unsigned bit_divisor(input int unsigned khz, input int unsigned bps);
    return (khz * 1000 + bps / 2) / bps;
  endfunction

  function automatic cmd_dec_t cmd_decode(input logic [7:0] b);
    cmd_dec_t d;
    d.hit = 1'b1;
    case (b)
      8'h30: d.op = OP_FLASH_WR;
      8'h60: d.op = OP_RAM_LOAD;
      8'h90: d.op = OP_FLASH_SUM;
      8'hC0: d.op = OP_IDENT;
      default: begin
        d.hit = 1'b0;
        d.op  = OP_FLASH_WR;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/isp_code_check.sv
module isp_code_check
  import isp_boot_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int CLK_SEL_W = $clog2(NUM_CLK),
  parameter logic [NUM_CLK-1:0][NUM_RATES-1:0] RATE_LEGAL = '1
) (
  input  logic [CLK_SEL_W-1:0] clk_sel,
  input  logic [7:0]           rx_data,
  output logic                 rate_ok,
  output logic [2:0]           rate_idx,
  output logic                 cmd_ok,
  output op_t                  cmd_op
);
  logic [NUM_RATES-1:0] hit;
  cmd_dec_t             dec;

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    assign hit[r] = (rx_data == rate_code(r)) && RATE_LEGAL[clk_sel][r];
  end

  always_comb begin
    rate_idx = 3'd0;
    for (int r = 0; r < NUM_RATES; r++) begin
      if (hit[r]) rate_idx = 3'(r);
    end
  end

  assign rate_ok = |hit;
  assign dec     = cmd_decode(rx_data);
  assign cmd_ok  = dec.hit;
  assign cmd_op  = dec.op;
endmodule

// File: rtl/isp_tx_repeater.sv
module isp_tx_repeater #(
  parameter int REPEAT = 3,
  parameter int CNT_W = $clog2(REPEAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] count,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             tx_done,
  output logic             done
);
  typedef enum logic [1:0] {R_IDLE, R_SEND, R_WAIT} rep_state_t;

  rep_state_t       st;
  logic [CNT_W-1:0] left;
  logic [7:0]       byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      left   <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        R_IDLE: if (start) begin
          byte_q <= byte_in;
          left   <= count;
          st     <= R_SEND;
        end
        R_SEND: if (tx_ready) st <= R_WAIT;
        R_WAIT: if (tx_done) begin
          if (left == CNT_W'(1)) st <= R_IDLE;
          else begin
            left <= left - CNT_W'(1);
            st   <= R_SEND;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assign tx_valid = (st == R_SEND);
  assign tx_data  = byte_q;
  assign done     = (st == R_WAIT) && tx_done && (left == CNT_W'(1));
endmodule

// File: rtl/isp_rate_reg.sv
module isp_rate_reg
  import isp_boot_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int CLK_SEL_W = $clog2(NUM_CLK),
  parameter int BASE_KHZ = 2000,
  parameter int DIV_W = 16,
  parameter int DEFAULT_IDX = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CLK_SEL_W-1:0] clk_sel,
  input  logic                 apply,
  input  logic [2:0]           new_idx,
  output logic [DIV_W-1:0]     baud_div
);
  logic [DIV_W-1:0] div_tab [NUM_CLK][NUM_RATES];
  logic [2:0]       cur_idx;

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_clk
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
      assign div_tab[c][r] = DIV_W'(bit_divisor(BASE_KHZ << c, rate_bps(r)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_idx <= 3'(DEFAULT_IDX);
    else if (apply) cur_idx <= new_idx;
  end

  assign baud_div = div_tab[clk_sel][cur_idx];
endmodule

// File: rtl/isp_boot_frontend.sv
module isp_boot_frontend
  import isp_boot_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int CLK_SEL_W = $clog2(NUM_CLK),
  parameter int BASE_KHZ = 2000,
  parameter int DIV_W = 16,
  parameter int ERR_REPEAT = 3,
  parameter logic [NUM_CLK-1:0][NUM_RATES-1:0] RATE_LEGAL =
    {6'b111111, 6'b111110, 6'b111000, 6'b100000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CLK_SEL_W-1:0] clk_sel,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_frame_err,
  input  logic                 rx_overrun,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  input  logic                 tx_ready,
  input  logic                 tx_done,
  output logic [DIV_W-1:0]     baud_div,
  output logic                 mode_start,
  output logic [1:0]           mode_op,
  input  logic                 mode_done,
  output logic                 error_locked
);
  localparam int CNT_W = $clog2(ERR_REPEAT + 1);

  fe_state_t  state, state_nx;
  op_t        op_q;
  logic [2:0] pend_idx;
  logic       start_q;

  logic             rate_ok, cmd_ok;
  logic [2:0]       rate_idx;
  op_t              cmd_op;
  logic             seq_start, seq_done;
  logic [7:0]       seq_byte;
  logic [CNT_W-1:0] seq_cnt;

  // named events for the checker
  logic evt_listen, evt_sync_hit, evt_fault, baud_apply, evt_cmd_accept;

  isp_code_check #(.NUM_CLK(NUM_CLK), .CLK_SEL_W(CLK_SEL_W), .RATE_LEGAL(RATE_LEGAL)) u_check (
    .clk_sel(clk_sel), .rx_data(rx_data), .rate_ok(rate_ok), .rate_idx(rate_idx),
    .cmd_ok(cmd_ok), .cmd_op(cmd_op)
  );

  isp_tx_repeater #(.REPEAT(ERR_REPEAT), .CNT_W(CNT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .byte_in(seq_byte), .count(seq_cnt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .done(seq_done)
  );

  isp_rate_reg #(.NUM_CLK(NUM_CLK), .CLK_SEL_W(CLK_SEL_W), .BASE_KHZ(BASE_KHZ),
                 .DIV_W(DIV_W), .DEFAULT_IDX(NUM_RATES - 1)) u_rate (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .apply(baud_apply),
    .new_idx(pend_idx), .baud_div(baud_div)
  );

  assign evt_listen   = rx_valid && (state == ST_RATE || state == ST_CMD);
  assign evt_fault    = evt_listen && (rx_frame_err || rx_overrun);
  assign evt_sync_hit = rx_valid && (state == ST_SYNC) && !rx_frame_err && !rx_overrun
                        && (rx_data == SYNC_BYTE);
  assign baud_apply     = seq_done && (state == ST_ECHO_RATE);
  assign evt_cmd_accept = seq_done && (state == ST_ECHO_CMD);

  always_comb begin
    state_nx  = state;
    seq_start = 1'b0;
    seq_byte  = rx_data;
    seq_cnt   = CNT_W'(1);
    case (state)
      ST_SYNC: if (evt_sync_hit) begin
        seq_start = 1'b1;
        state_nx  = ST_ECHO_SYNC;
      end
      ST_RATE, ST_CMD: if (rx_valid) begin
        seq_start = 1'b1;
        if (rx_frame_err || rx_overrun) begin
          seq_byte = rx_frame_err ? ERR_FRAME : ERR_OVR;
          seq_cnt  = CNT_W'(ERR_REPEAT);
          state_nx = ST_REPORT;
        end else if (state == ST_RATE) begin
          if (rate_ok) state_nx = ST_ECHO_RATE;
          else begin
            seq_byte = ERR_RATE;
            seq_cnt  = CNT_W'(ERR_REPEAT);
            state_nx = ST_REPORT;
          end
        end else begin
          if (cmd_ok) state_nx = ST_ECHO_CMD;
          else begin
            seq_byte = ERR_CMD;
            seq_cnt  = CNT_W'(ERR_REPEAT);
            state_nx = ST_REPORT;
          end
        end
      end
      ST_ECHO_SYNC: if (seq_done) state_nx = ST_RATE;
      ST_ECHO_RATE: if (seq_done) state_nx = ST_CMD;
      ST_ECHO_CMD:  if (seq_done) state_nx = ST_RUN;
      ST_RUN: if (mode_done && !start_q)
        state_nx = (op_q == OP_RAM_LOAD) ? ST_HANDOFF : ST_CMD;
      ST_REPORT: if (seq_done) state_nx = ST_LOCK;
      default: state_nx = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SYNC;
      op_q     <= OP_FLASH_WR;
      pend_idx <= '0;
      start_q  <= 1'b0;
    end else begin
      state   <= state_nx;
      start_q <= evt_cmd_accept;
      if (state == ST_RATE && rx_valid && rate_ok) pend_idx <= rate_idx;
      if (state == ST_CMD && rx_valid && cmd_ok)   op_q <= cmd_op;
    end
  end

  assign mode_start   = start_q;
  assign mode_op      = op_q;
  assign error_locked = (state == ST_LOCK);
endmodule

// File: rtl/isp_boot_checker.sv
module isp_boot_checker #(
  parameter int DIV_W = 16,
  parameter int CLK_SEL_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CLK_SEL_W-1:0] clk_sel,
  input logic                 tx_valid,
  input logic [7:0]           tx_data,
  input logic                 tx_ready,
  input logic                 tx_done,
  input logic [DIV_W-1:0]     baud_div,
  input logic                 mode_start,
  input logic                 error_locked,
  input logic                 evt_sync_hit,
  input logic                 baud_apply
);
  p_sync_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sync_hit |=> tx_valid && tx_data == 8'h5A);

  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_apply && $stable(clk_sel) |=> $stable(baud_div));

  p_apply_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_apply |-> tx_done);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_start |=> !mode_start);

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error_locked |=> error_locked);

  p_lock_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error_locked |-> !tx_valid && !mode_start);

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
endmodule

bind isp_boot_frontend isp_boot_checker #(.DIV_W(DIV_W), .CLK_SEL_W(CLK_SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .tx_done(tx_done), .baud_div(baud_div), .mode_start(mode_start),
  .error_locked(error_locked), .evt_sync_hit(evt_sync_hit), .baud_apply(baud_apply)
);

// File: tb/tb_isp_boot_frontend.sv
module tb_isp_boot_frontend;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_frame_err = 1'b0;
  logic        rx_overrun = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        tx_done = 1'b0;
  logic [15:0] baud_div;
  logic        mode_start;
  logic [1:0]  mode_op;
  logic        mode_done = 1'b0;
  logic        error_locked;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int stall = 0;

  isp_boot_frontend dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done), .baud_div(baud_div),
    .mode_start(mode_start), .mode_op(mode_op), .mode_done(mode_done),
    .error_locked(error_locked)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wire rate in bps for a rate byte, 0 when not a rate code
  function automatic int code_bps(input int code);
    case (code)
      8'h04: return 76800;
      8'h05: return 62500;
      8'h07: return 38400;
      8'h0A: return 31250;
      8'h18: return 19200;
      8'h28: return 9600;
      default: return 0;
    endcase
  endfunction

  function automatic int top_bps(input int sel);
    case (sel)
      0: return 9600;
      1: return 31250;
      2: return 62500;
      default: return 76800;
    endcase
  endfunction

  function automatic int exp_div(input int sel, input int bps);
    int hz;
    hz = 2000000 * (1 << sel);
    return (hz + bps / 2) / bps;
  endfunction

  task automatic do_reset(input int sel);
    @(negedge clk);
    rst_n = 1'b0;
    clk_sel = 2'(sel);
    rx_valid = 1'b0;
    tx_ready = 1'b0;
    tx_done = 1'b0;
    mode_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx_byte(input int b, input bit fe, input bit ov);
    rx_valid = 1'b1;
    rx_data = 8'(b);
    rx_frame_err = fe;
    rx_overrun = ov;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_frame_err = 1'b0;
    rx_overrun = 1'b0;
  endtask

  // accept one offered byte; leaves tx_done pending for the caller
  task automatic take_tx(input string tag, input int exp);
    int waited;
    waited = 0;
    while (!tx_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " tx byte"}, tx_valid ? int'(tx_data) : -1, exp);
    if (tx_valid) begin
      for (int s = 0; s < stall % 3; s++) begin
        @(negedge clk);
        check({tag, " R11 hold"}, int'(tx_data), exp);
      end
      stall++;
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic echo(input string tag, input int exp);
    take_tx(tag, exp);
    pulse_done();
  endtask

  task automatic expect_quiet(input string tag, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      if (tx_valid || mode_start) seen = 1;
      @(negedge clk);
    end
    check({tag, " quiet"}, seen, 0);
  endtask

  task automatic expect_report(input string tag, input int code);
    for (int k = 0; k < 3; k++) begin
      check({tag, " not locked before last"}, int'(error_locked), 0);
      echo(tag, code);
    end
    check({tag, " R9 locked"}, int'(error_locked), 1);
    rx_byte(8'h5A, 1'b0, 1'b0);
    rx_byte(8'h30, 1'b0, 1'b0);
    expect_quiet({tag, " R9"}, 10);
    check({tag, " R9 still locked"}, int'(error_locked), 1);
  endtask

  task automatic open_to_cmd(input int sel, input int code);
    do_reset(sel);
    rx_byte(8'h5A, 1'b0, 1'b0);
    echo("R2 sync", 8'h5A);
    rx_byte(code, 1'b0, 1'b0);
    echo("R3 rate", code);
  endtask

  initial begin
    // R1 reset state under every clock setting
    for (int s = 0; s < 4; s++) begin
      do_reset(s);
      check("R1 tx_valid", int'(tx_valid), 0);
      check("R1 mode_start", int'(mode_start), 0);
      check("R1 error_locked", int'(error_locked), 0);
      check("R1 baud_div", int'(baud_div), exp_div(s, 9600));
    end

    // R2 garbled and wrong bytes are ignored, then echo timing
    do_reset(3);
    rx_byte(8'h5A, 1'b1, 1'b0);
    rx_byte(8'h5A, 1'b0, 1'b1);
    rx_byte(8'h11, 1'b0, 1'b0);
    rx_byte(8'h28, 1'b0, 1'b0);
    expect_quiet("R2 ignore", 8);
    rx_byte(8'h5A, 1'b0, 1'b0);
    check("R2 echo next cycle", int'(tx_valid), 1);
    // R11 byte arriving during the echo is ignored
    rx_byte(8'hFF, 1'b0, 1'b0);
    echo("R2 sync", 8'h5A);
    expect_quiet("R11 during echo", 6);
    rx_byte(8'h28, 1'b0, 1'b0);
    echo("R11 rate after ignore", 8'h28);

    // R3 R4 R5 sweep of every rate byte under every clock setting
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 256; c++) begin
        int bps;
        do_reset(s);
        rx_byte(8'h5A, 1'b0, 1'b0);
        echo("R2 sync", 8'h5A);
        rx_byte(c, 1'b0, 1'b0);
        bps = code_bps(c);
        if (bps != 0 && bps <= top_bps(s)) begin
          take_tx("R3 rate echo", c);
          check("R4 old div during echo", int'(baud_div), exp_div(s, 9600));
          pulse_done();
          check("R4 new div", int'(baud_div), exp_div(s, bps));
        end else begin
          expect_report("R5 bad rate", 8'h62);
        end
      end
    end

    // R6 R7 R10 sweep of every command byte
    for (int c = 0; c < 256; c++) begin
      int op;
      op = (c == 8'h30) ? 0 : (c == 8'h60) ? 1 : (c == 8'h90) ? 2 : (c == 8'hC0) ? 3 : -1;
      open_to_cmd(3, 8'h04);
      rx_byte(c, 1'b0, 1'b0);
      if (op >= 0) begin
        take_tx("R6 cmd echo", c);
        check("R6 no early start", int'(mode_start), 0);
        pulse_done();
        check("R6 start", int'(mode_start), 1);
        check("R6 op", int'(mode_op), op);
        @(negedge clk);
        check("R6 start one cycle", int'(mode_start), 0);
        rx_byte(8'h90, 1'b0, 1'b0);
        expect_quiet("R11 during run", 5);
        mode_done = 1'b1;
        @(negedge clk);
        mode_done = 1'b0;
        if (op == 1) begin
          rx_byte(8'h30, 1'b0, 1'b0);
          rx_byte(8'h5A, 1'b0, 1'b0);
          expect_quiet("R10 handoff", 8);
          check("R10 handoff unlocked", int'(error_locked), 0);
        end else begin
          rx_byte(8'h90, 1'b0, 1'b0);
          echo("R10 next command", 8'h90);
        end
      end else begin
        expect_report("R7 bad command", 8'h63);
      end
    end

    // R8 receive faults in the rate phase and the command phase
    for (int ph = 0; ph < 2; ph++) begin
      for (int f = 1; f < 4; f++) begin
        if (ph == 0) begin
          do_reset(2);
          rx_byte(8'h5A, 1'b0, 1'b0);
          echo("R2 sync", 8'h5A);
        end else begin
          open_to_cmd(2, 8'h28);
        end
        rx_byte(8'h28, f[0], f[1]);
        expect_report("R8 fault", f[0] ? 8'hA1 : 8'hA3);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule